// File: doc/BRIEF.md
# Two-Wire Slave Byte-Memory Access Controller

This block is a slave on a two-wire serial bus. It oversamples the clock and data lines on a fast system clock, recognises START and STOP, matches a fixed 7-bit device address and gives the bus master byte access to a 32K x 8 space through a 15-bit pointer that advances by one after each byte. Most of the space is general RAM. A small window below the top is reserved, and the highest nine addresses hold timekeeping and control registers. The block flags accesses to that register window so a neighbouring clock unit can claim them.

A write transfer sends the device address with the direction bit clear, then two pointer bytes (upper byte first, its top bit ignored), then any number of data bytes. A read transfer sends the address with the direction bit set and receives bytes from the pointer onward until the master withholds its acknowledge. A power-fail input abandons any transfer, clears the pointer and deafens the slave while it stays high.

The controller is one state machine. Its states are ST_IDLE (bus ignored), ST_DEV (device byte in), ST_DEV_ACK, ST_PHI and ST_PHI_ACK (upper pointer byte), ST_PLO and ST_PLO_ACK (lower pointer byte), ST_WDAT and ST_WDAT_ACK (data written), ST_RDAT (byte out), ST_RDAT_ACK (master's acknowledge sampled) and ST_RHOLD (line released after a refusal). Transitions: START from any state goes to ST_DEV. STOP goes to ST_IDLE. A power-fail goes to ST_IDLE. A finished byte moves to the matching acknowledge state. The clock fall that ends an acknowledge moves to the next byte state. A device byte that does not match goes to ST_IDLE. A refused read byte goes to ST_RHOLD.

Top module: `twi_mem_target`

## Requirements
- R1: Only device byte 0xD0 (write) or 0xD1 (read), that is 7-bit address 0x68, is acknowledged. Any other address gets no acknowledge, and the slave then ignores the bus until the next START.
- R2: After reset and after STOP the slave drives nothing. Bits clocked after a STOP and before a START get no acknowledge and cause no memory write.
- R3: In a write transfer the two bytes after the device byte load the pointer, upper byte first. Bit 7 of the upper byte is ignored.
- R4: Each later write byte is acknowledged and stored at the pointer (mem_we pulse with mem_addr and mem_wdata), and the pointer then advances by one.
- R5: The pointer wraps from 0x7FFF to 0x0000, for both writes and reads.
- R6: Bytes written to 0x7FF0 to 0x7FF6 are acknowledged, but no mem_we is issued for them. The pointer still advances.
- R7: mem_reg_sel is high with each strobe whose address is 0x7FF7 or above, and low for lower addresses.
- R8: In a read transfer each byte is sent MSB first from the current pointer. Each byte the master acknowledges is followed by the next address.
- R9: After the master refuses a read byte, the slave leaves SDA released until the next START.
- R10: A repeated START keeps the pointer. A read with no pointer load continues at the byte after the last one sent.
- R11: While pfail_i is high the slave drives nothing, issues no strobes and acknowledges nothing. When pfail_i rises the pointer is cleared to 0x0000.
- R12: The slave changes SDA only while SCL is low, so each bit it sends stays stable across the whole SCL high time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | High pulls SDA low (open drain) |
| pfail_i | input | 1 | Power-fail abort, synchronous to clk |
| mem_addr | output | 15 | Address of the current memory strobe |
| mem_we | output | 1 | One-cycle write strobe |
| mem_re | output | 1 | One-cycle read strobe |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid in the cycle mem_re is high |
| mem_reg_sel | output | 1 | Strobe targets the register window |

## Verification
The assertions rely on the master making START and STOP only while the slave has SDA released, and on SCL staying low and high for several system clocks each. Under those conditions the slave's own SDA changes can only follow a detected SCL fall. The bench master runs each SCL quarter period over six system clocks, which is well above the required ratio. It changes SDA only at mid-low points and issues START or STOP only after each acknowledge clock has ended. The memory is modelled as a pure function of the address, so read data never depends on the order of earlier writes.

// File: rtl/twi_pkg.sv
package twi_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEV,
        ST_DEV_ACK,
        ST_PHI,
        ST_PHI_ACK,
        ST_PLO,
        ST_PLO_ACK,
        ST_WDAT,
        ST_WDAT_ACK,
        ST_RDAT,
        ST_RDAT_ACK,
        ST_RHOLD
    } state_t;

    typedef enum logic [1:0] {
        RGN_RAM,
        RGN_RSV,
        RGN_REG
    } region_t;

endpackage

// File: rtl/twi_sync.sv
// Multi-stage synchronizer per line, plus a one-cycle-old copy for edge detection.
module twi_sync #(
    parameter int STAGES = 2,
    parameter int LINES  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] din,
    output logic [LINES-1:0] dout,
    output logic [LINES-1:0] dprev
);

    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic [STAGES-1:0] chain;
        logic              last;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                chain <= '1;
                last  <= 1'b1;
            end else begin
                chain <= {chain[STAGES-2:0], din[g]};
                last  <= chain[STAGES-1];
            end
        end

        assign dout[g]  = chain[STAGES-1];
        assign dprev[g] = last;
    end

endmodule

// File: rtl/twi_cond.sv
// Bus condition decoder: START, STOP and SCL edges from synced levels.
module twi_cond (
    input  logic scl,
    input  logic sda,
    input  logic scl_p,
    input  logic sda_p,
    output logic start,
    output logic stop,
    output logic scl_rise,
    output logic scl_fall
);

    logic scl_held;

    always_comb begin
        scl_held = scl & scl_p;
        start    = scl_held & sda_p & ~sda;
        stop     = scl_held & ~sda_p & sda;
        scl_rise = scl & ~scl_p;
        scl_fall = ~scl & scl_p;
    end

endmodule

// File: rtl/twi_ptr.sv
// Address pointer with byte loads, wrap-around increment and region decode.
module twi_ptr #(
    parameter int          AW       = 15,
    parameter int unsigned RSV_BASE = 'h7FF0,
    parameter int unsigned REG_BASE = 'h7FF7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              ld_hi,
    input  logic              ld_lo,
    input  logic              inc,
    input  logic [7:0]        ld_byte,
    output logic [AW-1:0]     ptr,
    output twi_pkg::region_t  rgn
);

    localparam logic [AW-1:0] RSV_A = AW'(RSV_BASE);
    localparam logic [AW-1:0] REG_A = AW'(REG_BASE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr <= '0;
        end else if (clr) begin
            ptr <= '0;
        end else if (ld_hi) begin
            ptr <= AW'({ld_byte, ptr[7:0]});
        end else if (ld_lo) begin
            ptr[7:0] <= ld_byte;
        end else if (inc) begin
            ptr <= ptr + AW'(1);
        end
    end

    always_comb begin
        if (ptr >= REG_A) begin
            rgn = twi_pkg::RGN_REG;
        end else if (ptr >= RSV_A) begin
            rgn = twi_pkg::RGN_RSV;
        end else begin
            rgn = twi_pkg::RGN_RAM;
        end
    end

endmodule

// File: rtl/twi_mem_target.sv
module twi_mem_target #(
    parameter int          AW       = 15,
    parameter int          SYNC_LEN = 2,
    parameter logic [6:0]  DEV_ADDR = 7'h68,
    parameter int unsigned RSV_BASE = 'h7FF0,
    parameter int unsigned REG_BASE = 'h7FF7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          scl_i,
    input  logic          sda_i,
    output logic          sda_oe,
    input  logic          pfail_i,
    output logic [AW-1:0] mem_addr,
    output logic          mem_we,
    output logic          mem_re,
    output logic [7:0]    mem_wdata,
    input  logic [7:0]    mem_rdata,
    output logic          mem_reg_sel
);

    import twi_pkg::*;

    localparam int BITS = 8;

    logic [1:0] line_s, line_p;
    logic       scl_s, sda_s;
    logic       cond_start, cond_stop, scl_rise, scl_fall;

    state_t     state, nxt;
    logic [3:0] cnt;
    logic [7:0] shreg, tx, tx_nxt, rd_buf;
    logic       mack;
    logic       byte_done, rx_state, drv_nxt;

    logic          ptr_clr, ld_hi, ld_lo, inc, do_wr, do_fetch, load_tx;
    logic [AW-1:0] ptr;
    region_t       rgn;

    twi_sync #(.STAGES(SYNC_LEN), .LINES(2)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({scl_i, sda_i}),
        .dout  (line_s),
        .dprev (line_p)
    );

    assign scl_s = line_s[1];
    assign sda_s = line_s[0];

    twi_cond u_cond (
        .scl      (line_s[1]),
        .sda      (line_s[0]),
        .scl_p    (line_p[1]),
        .sda_p    (line_p[0]),
        .start    (cond_start),
        .stop     (cond_stop),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall)
    );

    twi_ptr #(.AW(AW), .RSV_BASE(RSV_BASE), .REG_BASE(REG_BASE)) u_ptr (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (ptr_clr),
        .ld_hi   (ld_hi),
        .ld_lo   (ld_lo),
        .inc     (inc),
        .ld_byte (shreg),
        .ptr     (ptr),
        .rgn     (rgn)
    );

    assign byte_done = scl_fall && (cnt == 4'(BITS));
    assign rx_state  = (state == ST_DEV) || (state == ST_PHI) ||
                       (state == ST_PLO) || (state == ST_WDAT);

    // next state and per-cycle control strobes
    always_comb begin
        nxt      = state;
        ptr_clr  = 1'b0;
        ld_hi    = 1'b0;
        ld_lo    = 1'b0;
        inc      = 1'b0;
        do_wr    = 1'b0;
        do_fetch = 1'b0;
        load_tx  = 1'b0;
        if (pfail_i) begin
            nxt     = ST_IDLE;
            ptr_clr = 1'b1;
        end else if (cond_start) begin
            nxt = ST_DEV;
        end else if (cond_stop) begin
            nxt = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE: ;
                ST_DEV: begin
                    if (byte_done) begin
                        if (shreg[7:1] == DEV_ADDR) begin
                            nxt      = ST_DEV_ACK;
                            do_fetch = shreg[0];
                        end else begin
                            nxt = ST_IDLE;
                        end
                    end
                end
                ST_DEV_ACK: begin
                    if (scl_fall) begin
                        if (shreg[0]) begin
                            nxt     = ST_RDAT;
                            load_tx = 1'b1;
                            inc     = 1'b1;
                        end else begin
                            nxt = ST_PHI;
                        end
                    end
                end
                ST_PHI: begin
                    if (byte_done) begin
                        nxt   = ST_PHI_ACK;
                        ld_hi = 1'b1;
                    end
                end
                ST_PHI_ACK: if (scl_fall) nxt = ST_PLO;
                ST_PLO: begin
                    if (byte_done) begin
                        nxt   = ST_PLO_ACK;
                        ld_lo = 1'b1;
                    end
                end
                ST_PLO_ACK: if (scl_fall) nxt = ST_WDAT;
                ST_WDAT: begin
                    if (byte_done) begin
                        nxt   = ST_WDAT_ACK;
                        do_wr = 1'b1;
                        inc   = 1'b1;
                    end
                end
                ST_WDAT_ACK: if (scl_fall) nxt = ST_WDAT;
                ST_RDAT: begin
                    if (byte_done) begin
                        nxt      = ST_RDAT_ACK;
                        do_fetch = 1'b1;
                    end
                end
                ST_RDAT_ACK: begin
                    if (scl_fall) begin
                        if (mack) begin
                            nxt     = ST_RDAT;
                            load_tx = 1'b1;
                            inc     = 1'b1;
                        end else begin
                            nxt = ST_RHOLD;
                        end
                    end
                end
                ST_RHOLD: ;
                default: nxt = ST_IDLE;
            endcase
        end
    end

    // transmit shifter and SDA drive decision
    always_comb begin
        if (load_tx) begin
            tx_nxt = rd_buf;
        end else if (state == ST_RDAT && scl_fall && cnt != 4'(BITS)) begin
            tx_nxt = {tx[6:0], 1'b1};
        end else begin
            tx_nxt = tx;
        end
        drv_nxt = (nxt == ST_DEV_ACK) || (nxt == ST_PHI_ACK) ||
                  (nxt == ST_PLO_ACK) || (nxt == ST_WDAT_ACK) ||
                  ((nxt == ST_RDAT) && !tx_nxt[7]);
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= nxt;
        end
    end

    // outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt         <= '0;
            shreg       <= '0;
            tx          <= '1;
            rd_buf      <= '0;
            mack        <= 1'b0;
            sda_oe      <= 1'b0;
            mem_we      <= 1'b0;
            mem_re      <= 1'b0;
            mem_addr    <= '0;
            mem_wdata   <= '0;
            mem_reg_sel <= 1'b0;
        end else begin
            if (pfail_i || cond_start || (nxt != state)) begin
                cnt <= '0;
            end else if (scl_rise && state != ST_IDLE && state != ST_RHOLD) begin
                cnt <= cnt + 4'd1;
            end
            if (scl_rise && rx_state) begin
                shreg <= {shreg[6:0], sda_s};
            end
            if (scl_rise && state == ST_RDAT_ACK) begin
                mack <= !sda_s;
            end
            tx     <= tx_nxt;
            sda_oe <= drv_nxt;
            mem_we <= do_wr && (rgn != RGN_RSV);
            mem_re <= do_fetch;
            if (do_wr || do_fetch) begin
                mem_addr    <= ptr;
                mem_reg_sel <= (rgn == RGN_REG);
            end
            if (do_wr) begin
                mem_wdata <= shreg;
            end
            if (mem_re) begin
                rd_buf <= mem_rdata;
            end
        end
    end

endmodule

// File: rtl/twi_mem_target_chk.sv
module twi_mem_target_chk #(
    parameter int          AW       = 15,
    parameter int unsigned RSV_BASE = 'h7FF0,
    parameter int unsigned REG_BASE = 'h7FF7
) (
    input logic          clk,
    input logic          rst_n,
    input logic          pfail,
    input logic          scl_s,
    input logic          start,
    input logic          stop,
    input logic          sda_oe,
    input logic          mem_we,
    input logic          mem_re,
    input logic [AW-1:0] mem_addr,
    input logic [AW-1:0] ptr,
    input logic          mem_reg_sel
);

    localparam logic [AW-1:0] RSV_A = AW'(RSV_BASE);
    localparam logic [AW-1:0] REG_A = AW'(REG_BASE);

    a_r12_sda_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n || pfail)
        (!$past(pfail) && $past(scl_s) && !$past(start) && !$past(stop)) |-> $stable(sda_oe));

    a_r2_stop_releases: assert property (@(posedge clk) disable iff (!rst_n)
        stop |=> !sda_oe);

    a_r6_no_reserved_write: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> !((mem_addr >= RSV_A) && (mem_addr < REG_A)));

    a_r7_regsel_window: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we || mem_re) |-> (mem_reg_sel == (mem_addr >= REG_A)));

    a_r4_ptr_past_write: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (ptr == mem_addr + AW'(1)));

    a_r4_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_we && mem_re));

    a_r11_pfail_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        pfail |=> (!sda_oe && !mem_we && !mem_re && ptr == '0));

endmodule

bind twi_mem_target twi_mem_target_chk #(
    .AW       (AW),
    .RSV_BASE (RSV_BASE),
    .REG_BASE (REG_BASE)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .pfail       (pfail_i),
    .scl_s       (scl_s),
    .start       (cond_start),
    .stop        (cond_stop),
    .sda_oe      (sda_oe),
    .mem_we      (mem_we),
    .mem_re      (mem_re),
    .mem_addr    (mem_addr),
    .ptr         (ptr),
    .mem_reg_sel (mem_reg_sel)
);

// File: tb/twi_mem_target_tb.sv
module twi_mem_target_tb_top;

    localparam int Q = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl_m = 1'b1;
    logic        sda_m = 1'b1;
    logic        pfail = 1'b0;
    logic        sda_oe, mem_we, mem_re, mem_reg_sel;
    logic [14:0] mem_addr;
    logic [7:0]  mem_wdata, mem_rdata;
    wire         sda_bus = sda_m & ~sda_oe;

    int nchk = 0;
    int nfail = 0;
    int unstable = 0;
    int nack_drive = 0;

    logic [14:0] wa [256];
    logic [7:0]  wd [256];
    logic        ws [256];
    int          wn = 0;

    always #2.5 clk = ~clk;

    twi_mem_target dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .scl_i       (scl_m),
        .sda_i       (sda_bus),
        .sda_oe      (sda_oe),
        .pfail_i     (pfail),
        .mem_addr    (mem_addr),
        .mem_we      (mem_we),
        .mem_re      (mem_re),
        .mem_wdata   (mem_wdata),
        .mem_rdata   (mem_rdata),
        .mem_reg_sel (mem_reg_sel)
    );

    function automatic logic [7:0] pat(input logic [14:0] a);
        return a[7:0] ^ {1'b0, a[14:8]} ^ 8'h5A;
    endfunction

    assign mem_rdata = mem_re ? pat(mem_addr) : 8'h00;

    always @(posedge clk) begin
        if (rst_n && mem_we) begin
            wa[wn[7:0]] <= mem_addr;
            wd[wn[7:0]] <= mem_wdata;
            ws[wn[7:0]] <= mem_reg_sel;
            wn <= wn + 1;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic qwait();
        repeat (Q) @(negedge clk);
    endtask

    task automatic m_start();
        sda_m = 1'b1; qwait();
        scl_m = 1'b1; qwait();
        sda_m = 1'b0; qwait();
        scl_m = 1'b0; qwait();
    endtask

    task automatic m_stop();
        sda_m = 1'b0; qwait();
        scl_m = 1'b1; qwait();
        sda_m = 1'b1; qwait();
    endtask

    task automatic send_bit(input logic b);
        sda_m = b; qwait();
        scl_m = 1'b1; qwait(); qwait();
        scl_m = 1'b0; qwait();
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        sda_m = 1'b1; qwait();
        scl_m = 1'b1; qwait();
        ack = !sda_bus;
        qwait();
        scl_m = 1'b0; qwait();
    endtask

    task automatic recv_byte(output logic [7:0] b, input logic give_ack);
        logic s0;
        for (int i = 7; i >= 0; i--) begin
            sda_m = 1'b1; qwait();
            scl_m = 1'b1; qwait();
            s0 = sda_bus;
            qwait();
            if (s0 !== sda_bus) unstable++;
            b[i] = sda_bus;
            scl_m = 1'b0; qwait();
        end
        sda_m = !give_ack; qwait();
        scl_m = 1'b1; qwait();
        if (!give_ack && sda_oe) nack_drive++;
        qwait();
        scl_m = 1'b0; qwait();
        sda_m = 1'b1;
    endtask

    task automatic load_ptr(input logic [7:0] hi, input logic [7:0] lo);
        logic ack;
        m_start();
        send_byte(8'hD0, ack); check("R1 write address ack", ack, 1);
        send_byte(hi, ack);    check("R3 pointer high ack", ack, 1);
        send_byte(lo, ack);    check("R3 pointer low ack", ack, 1);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        nchk++;
        nfail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

    initial begin : main
        logic       ack;
        logic [7:0] b;
        int         base;
        logic [14:0] ea;

        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // R2: reset state
        check("R2 reset sda_oe", sda_oe, 0);
        check("R2 reset strobes", {mem_we, mem_re}, 0);

        // R1: sweep all 7-bit addresses, write direction
        for (int a = 0; a < 128; a++) begin
            m_start();
            send_byte({7'(a), 1'b0}, ack);
            check("R1 address match", ack, (a == 'h68) ? 1 : 0);
            m_stop();
        end
        check("R1 no writes from address sweep", wn, 0);

        // R3 and R4: pointer load with top bit set, five data bytes
        base = wn;
        load_ptr(8'h92, 8'h34);
        for (int i = 0; i < 5; i++) begin
            send_byte(8'hA0 + 8'(i), ack);
            check("R4 data ack", ack, 1);
        end
        m_stop();
        qwait();
        check("R4 write count", wn - base, 5);
        for (int i = 0; i < 5; i++) begin
            check("R3 R4 write address", wa[base + i], 15'h1234 + 15'(i));
            check("R4 write data", wd[base + i], 8'hA0 + 8'(i));
            check("R7 ram select low", ws[base + i], 0);
        end

        // R5 and R7: wrap across the top
        base = wn;
        load_ptr(8'h7F, 8'hFE);
        for (int i = 0; i < 4; i++) begin
            send_byte(8'h10 + 8'(i), ack);
            check("R5 data ack", ack, 1);
        end
        m_stop();
        qwait();
        check("R5 write count", wn - base, 4);
        for (int i = 0; i < 4; i++) begin
            ea = 15'h7FFE + 15'(i);
            check("R5 wrapped address", wa[base + i], ea);
            check("R7 select by window", ws[base + i], (ea >= 15'h7FF7) ? 1 : 0);
        end

        // R6: run through the reserved window
        base = wn;
        load_ptr(8'h7F, 8'hEE);
        for (int i = 0; i < 11; i++) begin
            send_byte(8'hC0 + 8'(i), ack);
            check("R6 reserved still acked", ack, 1);
        end
        m_stop();
        qwait();
        check("R6 reserved writes dropped", wn - base, 4);
        begin
            int k = 0;
            for (int i = 0; i < 11; i++) begin
                ea = 15'h7FEE + 15'(i);
                if (!(ea >= 15'h7FF0 && ea <= 15'h7FF6)) begin
                    check("R6 kept address", wa[base + k], ea);
                    check("R6 kept data", wd[base + k], 8'hC0 + 8'(i));
                    check("R7 select after window", ws[base + k], (ea >= 15'h7FF7) ? 1 : 0);
                    k++;
                end
            end
        end

        // R8, R9, R10, R12: repeated START keeps pointer, sequential read
        load_ptr(8'h01, 8'h00);
        m_start();
        send_byte(8'hD1, ack);
        check("R1 read address ack", ack, 1);
        for (int i = 0; i < 6; i++) begin
            recv_byte(b, i != 5);
            check("R8 R10 read data", b, pat(15'h0100 + 15'(i)));
        end
        check("R9 released on refused byte", nack_drive, 0);
        send_bit(1'b1);
        check("R9 released after refusal", sda_oe, 0);
        m_stop();
        check("R12 sent bits stable while SCL high", unstable, 0);

        // R10: current-address read continues
        m_start();
        send_byte(8'hD1, ack);
        check("R10 read address ack", ack, 1);
        recv_byte(b, 1'b1);
        check("R10 continued data", b, pat(15'h0106));
        recv_byte(b, 1'b0);
        check("R10 continued data", b, pat(15'h0107));
        m_stop();

        // R5 and R8: read wraps through the register window
        load_ptr(8'h7F, 8'hFD);
        m_start();
        send_byte(8'hD1, ack);
        for (int i = 0; i < 4; i++) begin
            recv_byte(b, i != 3);
            check("R5 R8 read wrap data", b, pat(15'h7FFD + 15'(i)));
        end
        m_stop();

        // R2: bits after STOP without START
        base = wn;
        send_byte(8'hD0, ack);
        check("R2 no ack after stop", ack, 0);
        send_byte(8'h55, ack);
        check("R2 no ack on stray byte", ack, 0);
        check("R2 no write after stop", wn - base, 0);

        // R11: power-fail aborts, clears pointer, deafens
        base = wn;
        load_ptr(8'h22, 8'h33);
        for (int i = 0; i < 4; i++) send_bit(1'b1);
        pfail = 1'b1;
        qwait();
        check("R11 released on power fail", sda_oe, 0);
        m_start();
        send_byte(8'hD0, ack);
        check("R11 no ack during power fail", ack, 0);
        m_stop();
        pfail = 1'b0;
        qwait();
        check("R11 aborted write not stored", wn - base, 0);
        m_start();
        send_byte(8'hD1, ack);
        check("R11 ack after recovery", ack, 1);
        recv_byte(b, 1'b0);
        check("R11 pointer cleared", b, pat(15'h0000));
        m_stop();
        check("R12 sent bits stable while SCL high", unstable, 0);

        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

endmodule